// File: doc/BRIEF.md
# Return-from-Interruption State Restore Unit

This block carries out the return from an interruption handler in a simplified processor control path. When a single-cycle request arrives, it first checks the privilege rules against the live status word. If they pass, it copies the saved status word into the live status register and loads the saved address into the instruction pointer. It then switches the active bank for general registers 16 to 31 and issues a redirect with a flush. The flush causes every later fetch group, the target group included, to be fetched again. If the rules fail, a privilege fault is raised and nothing is changed.

The same operation can resume in a legacy 32-bit instruction mode. In that mode the pointer is cut to its low 32 bits, zero-extended, and a pulse tells the stack engine to make the current frame empty. The unit also flags two faults against the target. One is an illegal operation when the resume slot points into the second half of a long-immediate bundle. The other is a disabled floating-point register fault when the target is legacy code and the high floating-point registers are disabled. A diagnostic flag records whether the request came while interrupt collection or interrupt enable was still set, which is a misuse.

The state machine has four states. ST_IDLE waits for a request. ST_CHECK holds the captured operands and decides the outcome. ST_RESUME signals the redirect. ST_FAULT signals the privilege fault. The transitions are: accept (ST_IDLE to ST_CHECK on a request), commit (ST_CHECK to ST_RESUME when privilege allows), reject (ST_CHECK to ST_FAULT otherwise) and retire (ST_RESUME or ST_FAULT back to ST_IDLE).

Top module: `rfi_restore_unit`

## Requirements
- R1: After reset the live status word, instruction pointer, bank select, legacy mode, busy and every pulse output are all 0.
- R2: A request is accepted only in ST_IDLE. Busy is high for the two cycles after acceptance. Redirect and flush pulse together for exactly one cycle, the second cycle after acceptance. A request presented while busy is ignored.
- R3: On commit the live status word takes every bit of the saved word, and the instruction pointer takes the full saved address when the saved mode bit (bit 6) is 0.
- R4: While redirecting, the redirect slot equals bits [9:8] of the saved word and the redirect address equals the new instruction pointer.
- R5: The bank select takes bit 5 of the saved word. It changes only in the redirect cycle and keeps its old value during the checking cycle.
- R6: When the live privilege field (bits [3:2]) is non-zero or the live virtualization bit (bit 4) is 1, the unit pulses a privilege fault instead of a redirect. The status word, pointer and bank are then left unchanged.
- R7: The undefined-use flag equals the OR of live bit 0 (interrupt collection) and bit 1 (interrupt enable) at acceptance. It holds that value until the next acceptance and is cleared by reset.
- R8: The illegal-operation pulse accompanies the redirect exactly when the saved slot is 2, the long-template input is 1 and the saved mode bit is 0.
- R9: With saved mode bit 6 set, legacy mode becomes 1, the pointer becomes the low 32 bits of the saved address zero-extended, and a frame-clear pulse accompanies the redirect.
- R10: A disabled-FP pulse accompanies the redirect exactly when saved bit 6 and saved bit 7 are both 1.
- R11: A write through the status load port takes effect only in ST_IDLE and is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle restore request |
| sav_stat_i | input | STAT_W | Saved status word |
| sav_addr_i | input | ADDR_W | Saved interruption address |
| long_tmpl_i | input | 1 | Target bundle uses the long-immediate template |
| stat_ld_i | input | 1 | Load the live status word |
| stat_ld_data_i | input | STAT_W | Data for the status load |
| stat_o | output | STAT_W | Live status word |
| ip_o | output | ADDR_W | Instruction pointer |
| busy_o | output | 1 | Operation in progress |
| redir_o | output | 1 | Redirect pulse |
| redir_addr_o | output | ADDR_W | Redirect target address |
| redir_slot_o | output | 2 | Redirect resume slot |
| flush_o | output | 1 | Flush and refetch pulse |
| bank_o | output | 1 | Active bank for registers 16 to 31 |
| legacy_o | output | 1 | Legacy 32-bit mode active |
| frame_zero_o | output | 1 | Clear current stack frame size |
| priv_fault_o | output | 1 | Privilege fault pulse |
| illop_fault_o | output | 1 | Illegal-operation fault on the target |
| fpdis_fault_o | output | 1 | Disabled-FP-register fault on the target |
| undef_o | output | 1 | Undefined-use diagnostic flag |

## Verification
The hardest situation to bring about is a request, or a status write, that arrives while the unit is still in ST_CHECK or in a pulse state. Any such input must leave no trace. The bench raises a second request with a different address and a status write of all ones in the checking cycle. It then confirms that the committed values are those of the first request, and that busy stays low afterwards. The privilege and undefined-use rules are swept over every combination of the four live control fields. The restore outcome is swept over every combination of bank, mode, FP-high bit, slot and template.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
    // bit positions inside the status word; the decode depends on them
    localparam int F_IC     = 0;
    localparam int F_IEN    = 1;
    localparam int F_CPL_LO = 2;
    localparam int F_VM     = 4;
    localparam int F_BANK   = 5;
    localparam int F_ISA    = 6;
    localparam int F_FPHI   = 7;
    localparam int F_SLOT_LO = 8;
    localparam int MIN_STAT_W = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_RESUME = 2'd2,
        ST_FAULT  = 2'd3
    } rfi_state_e;

    typedef struct packed {
        logic priv_ok;
        logic undef;
        logic legacy;
        logic bank;
        logic illop;
        logic fpdis;
    } rfi_verdict_t;
endpackage

// File: rtl/rfi_rule_check.sv
module rfi_rule_check (
    input  logic [1:0]           live_cpl_i,
    input  logic                 live_vm_i,
    input  logic                 live_ic_i,
    input  logic                 live_ien_i,
    input  logic                 sav_bank_i,
    input  logic                 sav_isa_i,
    input  logic                 sav_fphi_i,
    input  logic [1:0]           sav_slot_i,
    input  logic                 long_tmpl_i,
    output rfi_pkg::rfi_verdict_t verdict_o
);
    always_comb begin
        verdict_o.priv_ok = (live_cpl_i == 2'd0) && !live_vm_i;
        verdict_o.undef   = live_ic_i | live_ien_i;
        verdict_o.legacy  = sav_isa_i;
        verdict_o.bank    = sav_bank_i;
        // second half of a long-immediate bundle is not a valid entry point
        verdict_o.illop   = (sav_slot_i == 2'd2) && long_tmpl_i && !sav_isa_i;
        verdict_o.fpdis   = sav_isa_i && sav_fphi_i;
    end
endmodule

// File: rtl/rfi_target_sel.sv
module rfi_target_sel #(
    parameter int ADDR_W = 64,
    parameter int LEG_W  = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              legacy_i,
    output logic [ADDR_W-1:0] target_o
);
    logic [ADDR_W-1:0] narrow;

    generate
        if (ADDR_W > LEG_W) begin : g_trunc
            assign narrow = {{(ADDR_W-LEG_W){1'b0}}, addr_i[LEG_W-1:0]};
        end else begin : g_fit
            assign narrow = addr_i;
        end
    endgenerate

    assign target_o = legacy_i ? narrow : addr_i;
endmodule

// File: rtl/rfi_ctrl_fsm.sv
module rfi_ctrl_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                priv_ok_i,
    output rfi_pkg::rfi_state_e state_o,
    output logic                accept_o,
    output logic                commit_o,
    output logic                busy_o
);
    import rfi_pkg::*;

    rfi_state_e state_q;
    rfi_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        commit_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (priv_ok_i) begin
                    commit_o = 1'b1;
                    state_d  = ST_RESUME;
                end else begin
                    state_d  = ST_FAULT;
                end
            end
            ST_RESUME: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/rfi_restore_unit.sv
module rfi_restore_unit #(
    parameter int ADDR_W = 64,
    parameter int LEG_W  = 32,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [STAT_W-1:0] sav_stat_i,
    input  logic [ADDR_W-1:0] sav_addr_i,
    input  logic              long_tmpl_i,
    input  logic              stat_ld_i,
    input  logic [STAT_W-1:0] stat_ld_data_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [ADDR_W-1:0] ip_o,
    output logic              busy_o,
    output logic              redir_o,
    output logic [ADDR_W-1:0] redir_addr_o,
    output logic [1:0]        redir_slot_o,
    output logic              flush_o,
    output logic              bank_o,
    output logic              legacy_o,
    output logic              frame_zero_o,
    output logic              priv_fault_o,
    output logic              illop_fault_o,
    output logic              fpdis_fault_o,
    output logic              undef_o
);
    import rfi_pkg::*;

    localparam int SLOT_HI = F_SLOT_LO + 1;
    localparam int CPL_HI  = F_CPL_LO + 1;

    rfi_state_e    state;
    logic          accept;
    logic          commit;
    rfi_verdict_t  verdict_now;
    rfi_verdict_t  verdict_q;

    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] sav_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ip_q;
    logic [ADDR_W-1:0] target;
    logic              bank_q;
    logic              legacy_q;
    logic              undef_q;

    // decide the outcome from live state and saved operands at acceptance
    rfi_rule_check u_rules (
        .live_cpl_i  (stat_q[CPL_HI:F_CPL_LO]),
        .live_vm_i   (stat_q[F_VM]),
        .live_ic_i   (stat_q[F_IC]),
        .live_ien_i  (stat_q[F_IEN]),
        .sav_bank_i  (sav_stat_i[F_BANK]),
        .sav_isa_i   (sav_stat_i[F_ISA]),
        .sav_fphi_i  (sav_stat_i[F_FPHI]),
        .sav_slot_i  (sav_stat_i[SLOT_HI:F_SLOT_LO]),
        .long_tmpl_i (long_tmpl_i),
        .verdict_o   (verdict_now)
    );

    rfi_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .priv_ok_i (verdict_q.priv_ok),
        .state_o   (state),
        .accept_o  (accept),
        .commit_o  (commit),
        .busy_o    (busy_o)
    );

    rfi_target_sel #(
        .ADDR_W (ADDR_W),
        .LEG_W  (LEG_W)
    ) u_tsel (
        .addr_i   (addr_q),
        .legacy_i (verdict_q.legacy),
        .target_o (target)
    );

    // operand capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sav_q     <= '0;
            addr_q    <= '0;
            verdict_q <= '0;
            undef_q   <= 1'b0;
        end else if (accept) begin
            sav_q     <= sav_stat_i;
            addr_q    <= sav_addr_i;
            verdict_q <= verdict_now;
            undef_q   <= verdict_now.undef;
        end
    end

    // architectural state: commit on the checking cycle, loads only when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q   <= '0;
            ip_q     <= '0;
            bank_q   <= 1'b0;
            legacy_q <= 1'b0;
        end else if (commit) begin
            stat_q   <= sav_q;
            ip_q     <= target;
            bank_q   <= verdict_q.bank;
            legacy_q <= verdict_q.legacy;
        end else if (stat_ld_i && (state == ST_IDLE)) begin
            stat_q   <= stat_ld_data_i;
        end
    end

    // outputs decoded from state
    always_comb begin
        redir_o       = 1'b0;
        flush_o       = 1'b0;
        frame_zero_o  = 1'b0;
        illop_fault_o = 1'b0;
        fpdis_fault_o = 1'b0;
        priv_fault_o  = 1'b0;
        unique case (state)
            ST_RESUME: begin
                redir_o       = 1'b1;
                flush_o       = 1'b1;
                frame_zero_o  = verdict_q.legacy;
                illop_fault_o = verdict_q.illop;
                fpdis_fault_o = verdict_q.fpdis;
            end
            ST_FAULT:  priv_fault_o = 1'b1;
            ST_IDLE:   ;
            ST_CHECK:  ;
            default:   ;
        endcase
    end

    assign stat_o       = stat_q;
    assign ip_o         = ip_q;
    assign redir_addr_o = ip_q;
    assign redir_slot_o = stat_q[SLOT_HI:F_SLOT_LO];
    assign bank_o       = bank_q;
    assign legacy_o     = legacy_q;
    assign undef_o      = undef_q;
endmodule

// File: rtl/rfi_restore_chk.sv
module rfi_restore_chk #(
    parameter int ADDR_W = 64,
    parameter int LEG_W  = 32,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              busy_o,
    input logic              redir_o,
    input logic              flush_o,
    input logic              bank_o,
    input logic              legacy_o,
    input logic [ADDR_W-1:0] ip_o,
    input logic [STAT_W-1:0] stat_o,
    input logic              priv_fault_o,
    input logic              illop_fault_o,
    input logic              fpdis_fault_o,
    input logic [1:0]        redir_slot_o
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> busy_o);
    // R2
    redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |=> !redir_o);
    // R2
    flush_with_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (flush_o && busy_o));
    // R5
    bank_on_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_o) |-> redir_o);
    // R6
    fault_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault_o |-> ($stable(stat_o) && $stable(ip_o) && $stable(bank_o) && !redir_o));
    // R8
    illop_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illop_fault_o |-> (redir_o && redir_slot_o == 2'd2 && !legacy_o));
    // R9
    legacy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_o |-> ((ip_o >> LEG_W) == '0));
    // R10
    fpdis_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fpdis_fault_o |-> (legacy_o && redir_o));
endmodule

bind rfi_restore_unit rfi_restore_chk #(
    .ADDR_W (ADDR_W),
    .LEG_W  (LEG_W),
    .STAT_W (STAT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .busy_o        (busy_o),
    .redir_o       (redir_o),
    .flush_o       (flush_o),
    .bank_o        (bank_o),
    .legacy_o      (legacy_o),
    .ip_o          (ip_o),
    .stat_o        (stat_o),
    .priv_fault_o  (priv_fault_o),
    .illop_fault_o (illop_fault_o),
    .fpdis_fault_o (fpdis_fault_o),
    .redir_slot_o  (redir_slot_o)
);

// File: tb/rfi_restore_unit_tb.sv
module rfi_restore_unit_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 64;
    localparam int LEG_W  = 32;
    localparam int STAT_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [STAT_W-1:0] sav_stat = '0;
    logic [ADDR_W-1:0] sav_addr = '0;
    logic              long_tmpl = 1'b0;
    logic              stat_ld = 1'b0;
    logic [STAT_W-1:0] stat_ld_data = '0;
    logic [STAT_W-1:0] stat_o;
    logic [ADDR_W-1:0] ip_o;
    logic              busy_o, redir_o, flush_o, bank_o, legacy_o, frame_zero_o;
    logic              priv_fault_o, illop_fault_o, fpdis_fault_o, undef_o;
    logic [ADDR_W-1:0] redir_addr_o;
    logic [1:0]        redir_slot_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    rfi_restore_unit #(.ADDR_W(ADDR_W), .LEG_W(LEG_W), .STAT_W(STAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sav_stat_i(sav_stat),
        .sav_addr_i(sav_addr), .long_tmpl_i(long_tmpl), .stat_ld_i(stat_ld),
        .stat_ld_data_i(stat_ld_data), .stat_o(stat_o), .ip_o(ip_o),
        .busy_o(busy_o), .redir_o(redir_o), .redir_addr_o(redir_addr_o),
        .redir_slot_o(redir_slot_o), .flush_o(flush_o), .bank_o(bank_o),
        .legacy_o(legacy_o), .frame_zero_o(frame_zero_o),
        .priv_fault_o(priv_fault_o), .illop_fault_o(illop_fault_o),
        .fpdis_fault_o(fpdis_fault_o), .undef_o(undef_o)
    );

    task automatic chk(input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
        end
    endtask

    // status word: [15:10] spare, [9:8] slot, 7 fp-high, 6 mode, 5 bank,
    // 4 virt, [3:2] privilege, 1 int enable, 0 int collection
    function automatic logic [15:0] mk(input logic [5:0] spare, input logic [1:0] slot,
                                       input logic fph, input logic isa, input logic bn,
                                       input logic vm, input logic [1:0] cpl,
                                       input logic ien, input logic ic);
        return {spare, slot, fph, isa, bn, vm, cpl, ien, ic};
    endfunction

    task automatic run_op(input logic [15:0] live, input logic [15:0] sav,
                          input logic [63:0] addr, input logic lt, input bit intrude);
        logic prev_bank;
        logic [63:0] prev_ip;
        logic fault;
        logic isa;
        logic [63:0] exp_ip;
        logic [1:0] slot;
        @(negedge clk);
        stat_ld = 1'b1; stat_ld_data = live;
        @(negedge clk);
        stat_ld = 1'b0;
        chk("R11", "idle load", stat_o, live);
        prev_bank = bank_o;
        prev_ip   = ip_o;
        req = 1'b1; sav_stat = sav; sav_addr = addr; long_tmpl = lt;
        @(negedge clk);
        req = 1'b0;
        chk("R2", "busy after accept", busy_o, 1);
        chk("R2", "no early redirect", redir_o, 0);
        chk("R5", "old bank while checking", bank_o, prev_bank);
        if (intrude) begin
            req = 1'b1; sav_addr = ~addr;
            stat_ld = 1'b1; stat_ld_data = 16'hFFFF;
        end
        @(negedge clk);
        req = 1'b0; stat_ld = 1'b0;
        fault  = (live[3:2] != 2'd0) || live[4];
        isa    = sav[6];
        slot   = sav[9:8];
        exp_ip = isa ? {32'h0, addr[31:0]} : addr;
        chk("R2", "redirect pulse", redir_o, !fault);
        chk("R2", "flush pulse", flush_o, !fault);
        chk("R6", "privilege fault", priv_fault_o, fault);
        chk("R7", "undefined flag", undef_o, live[0] | live[1]);
        if (fault) begin
            chk("R6", "status kept", stat_o, live);
            chk("R6", "ip kept", ip_o, prev_ip);
            chk("R6", "bank kept", bank_o, prev_bank);
        end else begin
            chk("R3", "status restored", stat_o, sav);
            chk(isa ? "R9" : "R3", "ip loaded", ip_o, exp_ip);
            chk("R4", "redirect addr", redir_addr_o, exp_ip);
            chk("R4", "redirect slot", redir_slot_o, slot);
            chk("R5", "bank switched", bank_o, sav[5]);
            chk("R9", "legacy mode", legacy_o, isa);
            chk("R9", "frame clear", frame_zero_o, isa);
            chk("R8", "illegal op", illop_fault_o, (slot == 2'd2) && lt && !isa);
            chk("R10", "fp disabled", fpdis_fault_o, isa && sav[7]);
        end
        @(negedge clk);
        chk("R2", "idle after pulse", busy_o, 0);
        chk("R2", "pulse one cycle", redir_o | priv_fault_o, 0);
        @(negedge clk);
        chk("R2", "no second accept", busy_o, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL R2 watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset status", stat_o, 0);
        chk("R1", "reset ip", ip_o, 0);
        chk("R1", "reset bank", bank_o, 0);
        chk("R1", "reset legacy", legacy_o, 0);
        chk("R1", "reset busy", busy_o, 0);
        chk("R1", "reset pulses", {redir_o, flush_o, priv_fault_o, illop_fault_o,
                                   fpdis_fault_o, frame_zero_o, undef_o}, 0);

        // privilege and undefined-use sweep over every live control combination
        for (int k = 0; k < 32; k++) begin
            logic [15:0] live;
            logic [15:0] sav;
            live = mk(6'(k * 5), 2'(k), 1'b0, 1'b0, 1'b0, k[4], k[3:2], k[1], k[0]);
            sav  = mk(6'(k * 3), 2'd1, 1'b0, 1'b0, k[0] ^ k[2], 1'b0, 2'd0, 1'b0, 1'b0);
            run_op(live, sav, 64'h1000_0000_0000_0000 + 64'(k) * 64'h10, 1'b0, 1'b0);
        end

        // restore outcome sweep: bank, mode, fp-high, slot, template
        for (int k = 0; k < 64; k++) begin
            logic [15:0] sav;
            logic [63:0] addr;
            sav  = mk(6'(k * 7 + 1), k[5:4], k[3], k[2], k[1], 1'b0, 2'd0, 1'b0, 1'b0);
            addr = 64'hA5A5_0000_0000_0000 ^ (64'(k) * 64'h0123_4567_89AB_CDE0);
            run_op(16'h0000, sav, addr, k[0], 1'b0);
        end

        // requests and status writes while busy are ignored
        run_op(16'h0000, mk(6'h2A, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0),
               64'hDEAD_BEEF_0000_1230, 1'b1, 1'b1);
        run_op(16'h0004, mk(6'h15, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0),
               64'h0000_0000_0000_4440, 1'b0, 1'b1);

        // undefined flag cleared by reset
        run_op(16'h0001, mk(6'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0),
               64'h0000_0000_0000_8880, 1'b0, 1'b0);
        chk("R7", "flag held", undef_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "flag cleared by reset", undef_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule